// File: doc/BRIEF.md
# Four-Phase Read Handshake Link

This block carries one read transaction at a time between a device-side requester and a memory-side responder over a request/acknowledge protocol that needs no shared timing. Both ends sit inside the block, clocked by one clock. Every control wire that runs from one end to the other passes through a two-flop synchronizer first, so the exchange stays correct for any delay between the ends. Address and read data travel over one set of shared data lines. Each end has its own driver enable for those lines.

A user pulses `start_i` with an address. The requester raises its read request and drives the address onto the shared lines. The responder latches the address and acknowledges it. The request is then released, and the acknowledge is released after it. After a configurable fetch delay, the responder puts the word from its small internal register file on the lines and raises data-ready. The requester takes the word and acknowledges it. Data-ready falls, that acknowledge falls, and the user sees the word on `data_o` together with a one-cycle `done_o` pulse.

Top module: `rdhs_link`

## Requirements
- R1: During reset and after it, with no start, `busy_o` and `done_o` are 0 and `data_o` is all zeros.
- R2: A start accepted in idle raises the read request and drives the address onto the shared lines, which stay stable while the request is high. The responder raises its address acknowledge only while the request is high. The requester drops the request and its line driver only after it sees that acknowledge.
- R3: The address acknowledge falls only after the read request is low.
- R4: After the address acknowledge falls, and LAT cycles after the responder sees that (LAT from 1 to 16), the responder drives the read word onto the lines and raises data-ready. It does this only while both acknowledges are low.
- R5: The data acknowledge rises only while data-ready is high. Data-ready and the responder's line driver drop only while the data acknowledge is high. The data acknowledge falls in the same cycle that `done_o` is asserted.
- R6: The two line drivers are never enabled in the same cycle.
- R7: `done_o` is a single-cycle pulse that is asserted exactly 18+LAT clock edges after the edge that accepted the start, which is six crossings of three register stages each, plus the fetch delay. `busy_o` is 1 from the edge after acceptance up to the edge that asserts `done_o`.
- R8: A `start_i` that arrives while `busy_o` is 1 is ignored. It produces no extra `done_o`, and the returned word belongs to the first address.
- R9: The word returned for address a is ((a*37 + 11) XOR (a*8)) modulo 2^DW.
- R10: `data_o` holds the last returned word until the next `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a read; sampled only when idle |
| addr_i | input | AW | Read address, sampled with start_i |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse: data_o carries the new word |
| data_o | output | DW | Last word read |

## Verification
The returned word is due exactly 18+LAT edges after the edge that accepted the start, and `busy_o` is due on the first edge after it. The bench drives stimulus on falling edges and counts falling edges from the accepting edge. It records the exact edge at which each `done_o` appears and compares that edge with the due value. Four copies with fetch delays of 1, 4, 9 and 16 run in parallel over every address. The bench waits 60 edges after each start, which is past the slowest copy's completion and the return of its responder to idle. At the end of that window it checks that `data_o` is unchanged, that `busy_o` is low, and that a start poked mid-transfer added no completion.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE, RQ_ADDR, RQ_RELEASE, RQ_WAIT, RQ_TAKE
  } rq_state_e;

  typedef enum logic [2:0] {
    RS_IDLE, RS_HOLD, RS_FETCH, RS_SEND, RS_CLOSE
  } rs_state_e;

  // Content of the modelled memory at address a (caller truncates to DW).
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'd37 + 32'd11) ^ (a << 3);
  endfunction

  // Edges from start acceptance to done: six crossings, each crossing is
  // the synchronizer stages plus the reacting state register, plus fetch.
  function automatic int unsigned done_delay(input int unsigned stages,
                                             input int unsigned lat);
    return 6 * (stages + 1) + lat;
  endfunction

endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rdhs_requester.sv
module rdhs_requester
  import rdhs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ack_s,
  input  logic          rdy_s,
  input  logic [DW-1:0] bus_i,
  output logic          read_req,
  output logic          data_ack,
  output logic          drv_en,
  output logic [DW-1:0] drv_data,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] data_o
);
  rq_state_e     state;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RQ_IDLE;
      addr_q <= '0;
      data_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        RQ_IDLE:    if (start_i) begin
                      addr_q <= addr_i;
                      state  <= RQ_ADDR;
                    end
        RQ_ADDR:    if (ack_s)  state <= RQ_RELEASE;
        RQ_RELEASE: if (!ack_s) state <= RQ_WAIT;
        RQ_WAIT:    if (rdy_s) begin
                      data_o <= bus_i;
                      state  <= RQ_TAKE;
                    end
        RQ_TAKE:    if (!rdy_s) begin
                      done_o <= 1'b1;
                      state  <= RQ_IDLE;
                    end
        default:    state <= RQ_IDLE;
      endcase
    end
  end

  assign read_req = (state == RQ_ADDR);
  assign drv_en   = (state == RQ_ADDR);
  assign data_ack = (state == RQ_TAKE);
  assign drv_data = DW'(addr_q);
  assign busy_o   = (state != RQ_IDLE);
endmodule

// File: rtl/rdhs_responder.sv
module rdhs_responder
  import rdhs_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s,
  input  logic          dack_s,
  input  logic [AW-1:0] bus_addr,
  output logic          addr_ack,
  output logic          data_rdy,
  output logic          drv_en,
  output logic [DW-1:0] drv_data,
  output logic [AW-1:0] addr_q
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT + 1);

  rs_state_e     state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] rf [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rf[i] <= DW'(mem_word(32'(i)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RS_IDLE;
      cnt    <= '0;
      rd_q   <= '0;
      addr_q <= '0;
    end else begin
      unique case (state)
        RS_IDLE:  if (req_s) begin
                    addr_q <= bus_addr;
                    state  <= RS_HOLD;
                  end
        RS_HOLD:  if (!req_s) begin
                    cnt   <= CW'(LAT);
                    state <= RS_FETCH;
                  end
        RS_FETCH: if (cnt == CW'(1)) begin
                    rd_q  <= rf[addr_q];
                    state <= RS_SEND;
                  end else begin
                    cnt <= cnt - CW'(1);
                  end
        RS_SEND:  if (dack_s)  state <= RS_CLOSE;
        RS_CLOSE: if (!dack_s) state <= RS_IDLE;
        default:  state <= RS_IDLE;
      endcase
    end
  end

  assign addr_ack = (state == RS_HOLD);
  assign data_rdy = (state == RS_SEND);
  assign drv_en   = (state == RS_SEND);
  assign drv_data = rd_q;
endmodule

// File: rtl/rdhs_link.sv
module rdhs_link
  import rdhs_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int LAT    = 4,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] data_o
);
  // Named handshake wires, visible to the bound checker.
  logic          read_req, addr_ack, data_rdy, data_ack;
  logic          req_s, ack_s, rdy_s, dack_s;
  logic          req_en, rsp_en;
  logic [DW-1:0] req_drv, rsp_drv, bus;
  logic [AW-1:0] rsp_addr;

  // Shared data lines: whichever end enables its driver owns them.
  always_comb begin
    if (req_en)      bus = req_drv;
    else if (rsp_en) bus = rsp_drv;
    else             bus = '0;
  end

  rdhs_sync #(.STAGES(STAGES)) u_sync_req  (.clk(clk), .rst_n(rst_n), .d(read_req), .q(req_s));
  rdhs_sync #(.STAGES(STAGES)) u_sync_ack  (.clk(clk), .rst_n(rst_n), .d(addr_ack), .q(ack_s));
  rdhs_sync #(.STAGES(STAGES)) u_sync_rdy  (.clk(clk), .rst_n(rst_n), .d(data_rdy), .q(rdy_s));
  rdhs_sync #(.STAGES(STAGES)) u_sync_dack (.clk(clk), .rst_n(rst_n), .d(data_ack), .q(dack_s));

  rdhs_requester #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .ack_s(ack_s), .rdy_s(rdy_s), .bus_i(bus),
    .read_req(read_req), .data_ack(data_ack),
    .drv_en(req_en), .drv_data(req_drv),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o)
  );

  rdhs_responder #(.AW(AW), .DW(DW), .LAT(LAT)) u_rsp (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .dack_s(dack_s),
    .bus_addr(bus[AW-1:0]),
    .addr_ack(addr_ack), .data_rdy(data_rdy),
    .drv_en(rsp_en), .drv_data(rsp_drv), .addr_q(rsp_addr)
  );
endmodule

// File: rtl/rdhs_link_chk.sv
module rdhs_link_chk
  import rdhs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          read_req,
  input logic          addr_ack,
  input logic          data_rdy,
  input logic          data_ack,
  input logic          req_en,
  input logic          rsp_en,
  input logic [DW-1:0] bus,
  input logic          done_o,
  input logic [DW-1:0] data_o,
  input logic [AW-1:0] rsp_addr
);
  // R6
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_en && rsp_en));

  // R2
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_ack) |-> read_req);

  // R2
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(read_req) |-> addr_ack && !req_en);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_req && $past(read_req) |-> $stable(bus));

  // R3
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_ack) |-> !read_req);

  // R4
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |-> !addr_ack && !data_ack && rsp_en);

  // R5
  dack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ack) |-> data_rdy);

  // R5
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_rdy) |-> data_ack && !rsp_en);

  // R5
  dack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ack) |-> done_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  data_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> data_o == DW'(mem_word(32'(rsp_addr))));
endmodule

bind rdhs_link rdhs_link_chk #(.AW(AW), .DW(DW)) u_rdhs_link_chk (
  .clk(clk), .rst_n(rst_n), .read_req(read_req), .addr_ack(addr_ack),
  .data_rdy(data_rdy), .data_ack(data_ack), .req_en(req_en),
  .rsp_en(rsp_en), .bus(bus), .done_o(done_o), .data_o(data_o),
  .rsp_addr(rsp_addr)
);

// File: tb/rdhs_link_bench.sv
`timescale 1ns/1ps
module rdhs_link_bench;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int LANES = 4;
  localparam int WIN   = 60;
  localparam int LAT_TAB [LANES] = '{1, 4, 9, 16};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          busy [LANES];
  logic          done [LANES];
  logic [DW-1:0] dout [LANES];

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rdhs_link #(.AW(AW), .DW(DW), .LAT(LAT_TAB[g])) u_rdhs_link (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
      .busy_o(busy[g]), .done_o(done[g]), .data_o(dout[g])
    );
  end

  // Word expected at address a, restated with shifts and masks.
  function automatic int exp_word(input int a);
    int prod;
    prod = (a << 5) + (a << 2) + a + 11;
    return (prod ^ (a << 3)) & 8'hFF;
  endfunction

  // Three registers per crossing (two sync flops, one state flop), six crossings.
  function automatic int exp_due(input int lat);
    return 3 + 3 + 3 + 3 + 3 + 3 + lat;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // One transaction on all lanes; optionally poke a start while busy.
  task automatic run_one(input int a, input bit poke, input int poke_a);
    int done_at [LANES];
    int n_done  [LANES];
    int held    [LANES];
    foreach (done_at[g]) begin done_at[g] = -1; n_done[g] = 0; held[g] = 0; end
    @(negedge clk);
    start = 1'b1;
    addr  = AW'(a);
    @(negedge clk);
    start = 1'b0;
    // now just after the accepting edge (k = 1 below is the next edge)
    for (int k = 1; k <= WIN; k++) begin
      if (poke && k == 5) begin start = 1'b1; addr = AW'(poke_a); end
      if (poke && k == 6) start = 1'b0;
      @(negedge clk);
      for (int g = 0; g < LANES; g++) begin
        if (k == 1) chk(busy[g] == 1'b1, "R7 busy after accept", int'(busy[g]), 1);
        if (done[g]) begin
          n_done[g]++;
          if (done_at[g] < 0) begin done_at[g] = k; held[g] = int'(dout[g]); end
        end
      end
      // Busy must be high strictly between acceptance and the done edge.
      for (int g = 0; g < LANES; g++)
        if (k == exp_due(LAT_TAB[g]) - 1)
          chk(busy[g] == 1'b1, "R7 busy until done", int'(busy[g]), 1);
    end
    for (int g = 0; g < LANES; g++) begin
      // done timing covers the ordered exchange R2 R3 R4 R5
      chk(done_at[g] == exp_due(LAT_TAB[g]), "R7 done edge (R2 R3 R4 R5)",
          done_at[g], exp_due(LAT_TAB[g]));
      chk(n_done[g] == 1, poke ? "R8 single done despite busy start" : "R7 single done",
          n_done[g], 1);
      chk(held[g] == exp_word(a), poke ? "R8 word of first address" : "R6/R9 returned word",
          held[g], exp_word(a));
      chk(int'(dout[g]) == exp_word(a), "R10 data held", int'(dout[g]), exp_word(a));
      chk(busy[g] == 1'b0, "R7 idle after done", int'(busy[g]), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int g = 0; g < LANES; g++) begin
      chk(busy[g] == 1'b0, "R1 busy in reset", int'(busy[g]), 0);
      chk(done[g] == 1'b0, "R1 done in reset", int'(done[g]), 0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int g = 0; g < LANES; g++) begin
      chk(busy[g] == 1'b0, "R1 busy idle", int'(busy[g]), 0);
      chk(done[g] == 1'b0, "R1 done idle", int'(done[g]), 0);
      chk(dout[g] == '0, "R1 data zero", int'(dout[g]), 0);
    end
    for (int a = 0; a < (1 << AW); a++) run_one(a, 1'b0, 0);
    for (int a = (1 << AW) - 1; a >= 0; a--) run_one(a, 1'b1, (a + 7) % (1 << AW));
    report();
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    report();
  end
endmodule